// File: doc/BRIEF.md
# Multiplexed parallel I/O bank

The block is a bank of general-purpose pins behind a small register bus. Each pin can be handed to the bank's own GPIO logic or to one of two on-chip peripheral functions, called A and B. Each pin attribute is a one-bit-per-pin vector that software changes through a pair of write-one registers, one that sets bits and one that clears them. Bits written as zero are left alone, so drivers never need read-modify-write sequences. The attributes are GPIO ownership, A/B choice, output data, output enable, pull-up, input glitch filter, open-drain multi-drive and interrupt mask. Each can be read back through a status word.

Pad inputs are synchronised through two flops and can optionally be glitch-filtered. They are readable as live levels whatever the pin's mux setting. Every change of the synchronised level, rising or falling, raises a per-pin flag. Reading the flag word returns the flags and clears them. The bank interrupt output is high while any flagged pin is also unmasked. The bus read path is combinational, so a read returns data in the cycle its select is asserted. Writes take effect at the clock edge.

Top module: `pio_bank`

## Requirements
- R1: After reset every pin is GPIO (status 0x08 reads all ones), output enable (0x18), output data (0x38), filter (0x28), multi-drive (0x58) and mask (0x48) read zero, pull-up status (0x68) reads all ones, pad_oe is all zero, pad_pu all ones and irq is low.
- R2: Writing 0x00 gives the pins whose write bits are 1 to GPIO, writing 0x04 hands them to a peripheral, and pins written 0 keep their setting; 0x08 shows the ownership, 1 meaning GPIO.
- R3: Writing 0x70 selects peripheral A (A/B bit 0) and writing 0x74 selects peripheral B (bit 1) for the pins written 1; 0x78 shows the bits, and a non-GPIO pin drives pad_out and pad_oe from per_a_* when its bit is 0 and from per_b_* when it is 1.
- R4: Writing 0x30 sets and 0x34 clears output data bits for pins written 1; 0x38 shows the data, and a GPIO pin without multi-drive drives the data bit on pad_out.
- R5: Writing 0x10 enables and 0x14 disables the GPIO output of pins written 1; 0x18 shows it, and a GPIO pin without multi-drive has pad_oe equal to its enable bit.
- R6: Writing 0x50 enables and 0x54 disables multi-drive, shown at 0x58; on such a pin pad_out is 0 and pad_oe is high only while the selected output value is 0.
- R7: Writing 0x64 enables and 0x60 disables the pull-up, shown at 0x68 (1 = enabled) and driven on pad_pu.
- R8: Offset 0x3C returns each pin's level after a two-flop synchroniser, for GPIO and peripheral pins alike; per_a_in and per_b_in carry pad_in unchanged.
- R9: Writing 0x20 enables and 0x24 disables the glitch filter, shown at 0x28; a filtered pin ignores a pulse held for one clock and accepts one held for two, while an unfiltered pin flags both.
- R10: Every rising and every falling edge of a pin's accepted level sets its flag at 0x4C; 0x40 sets and 0x44 clears mask bits shown at 0x48, and irq is high while any flag has its mask bit set.
- R11: A read of 0x4C returns the flags and clears them, except that a flag whose edge arrives in the cycle of that read is kept.
- R12: The set, clear, unused offsets such as 0x7C read zero, and writes to the status, pin-level and flag offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NPINS | Write data, bit n = pin n |
| bus_rdata | output | NPINS | Read data, valid while a read is selected |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_in | input | NPINS | Pad input level |
| pad_pu | output | NPINS | Pad pull-up enable |
| per_a_out | input | NPINS | Peripheral A output value |
| per_a_oe | input | NPINS | Peripheral A output enable |
| per_a_in | output | NPINS | Pad input level to peripheral A |
| per_b_out | input | NPINS | Peripheral B output value |
| per_b_oe | input | NPINS | Peripheral B output enable |
| per_b_in | output | NPINS | Pad input level to peripheral B |
| irq | output | 1 | Bank interrupt, high while an unmasked flag is set |

## Verification
A register write is due on a read in the following cycle, and the pad outputs change at that same edge because they decode the registers without further flops. A pin level change is due at 0x3C two edges after it is driven. Its flag and irq are due one edge later, or two edges later again on a filtered pin. The bench drives every input on a falling edge, counts the rising edges before each read, and reads once before the due edge to see the old value and once after it. The kept-flag case is timed so that the read's own edge is the edge that records the change.

// File: rtl/pio_bank_pkg.sv
package pio_bank_pkg;
   // attribute indices into the packed attribute array
   localparam int N_ATTR  = 8;
   localparam int AT_PIO  = 0;
   localparam int AT_OE   = 1;
   localparam int AT_FILT = 2;
   localparam int AT_DATA = 3;
   localparam int AT_MASK = 4;
   localparam int AT_MD   = 5;
   localparam int AT_PU   = 6;
   localparam int AT_BSEL = 7;

   // byte offsets: set-ones, clear-ones and readback per attribute
   localparam int unsigned SET_OFF [N_ATTR] = '{32'h00, 32'h10, 32'h20, 32'h30,
                                                32'h40, 32'h50, 32'h64, 32'h74};
   localparam int unsigned CLR_OFF [N_ATTR] = '{32'h04, 32'h14, 32'h24, 32'h34,
                                                32'h44, 32'h54, 32'h60, 32'h70};
   localparam int unsigned STS_OFF [N_ATTR] = '{32'h08, 32'h18, 32'h28, 32'h38,
                                                32'h48, 32'h58, 32'h68, 32'h78};
   // reset fill of each attribute vector
   localparam bit RST_ONE [N_ATTR] = '{1'b1, 1'b0, 1'b0, 1'b0,
                                       1'b0, 1'b0, 1'b1, 1'b0};

   localparam int unsigned LEVEL_OFF = 32'h3C;
   localparam int unsigned FLAG_OFF  = 32'h4C;
endpackage

// File: rtl/pio_bank_setclr.sv
module pio_bank_setclr #(
   parameter int W       = 32,
   parameter bit RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] mask,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= {W{RST_VAL}};
      else if (set_stb) q <= q | mask;
      else if (clr_stb) q <= q & ~mask;
   end

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((q & $past(mask)) == $past(mask))); // R2
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_stb) |=> ((q & $past(mask)) == '0)); // R4
   AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb || clr_stb) |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask)))); // R2
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_stb || clr_stb) |=> $stable(q)); // R12
endmodule

// File: rtl/pio_bank_regs.sv
module pio_bank_regs
   import pio_bank_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           bus_sel,
   input  logic                           bus_wr,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic [NPINS-1:0]               bus_wdata,
   input  logic [NPINS-1:0]               pin_level,
   input  logic [NPINS-1:0]               flags,
   output logic [NPINS-1:0]               bus_rdata,
   output logic                           flag_read,
   output logic [N_ATTR-1:0][NPINS-1:0]   attr_q
);
   logic        wr_stb;
   logic        rd_stb;
   logic [31:0] addr_w;

   assign wr_stb    = bus_sel & bus_wr;
   assign rd_stb    = bus_sel & ~bus_wr;
   assign addr_w    = 32'(bus_addr);
   assign flag_read = rd_stb && (addr_w == FLAG_OFF);

   for (genvar k = 0; k < N_ATTR; k++) begin : g_attr
      logic set_hit;
      logic clr_hit;
      assign set_hit = wr_stb && (addr_w == SET_OFF[k]);
      assign clr_hit = wr_stb && (addr_w == CLR_OFF[k]);
      pio_bank_setclr #(.W(NPINS), .RST_VAL(RST_ONE[k])) u_bits (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_stb (set_hit),
         .clr_stb (clr_hit),
         .mask    (bus_wdata),
         .q       (attr_q[k])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_stb) begin
         for (int k = 0; k < N_ATTR; k++) begin
            if (addr_w == STS_OFF[k]) bus_rdata = attr_q[k];
         end
         if (addr_w == LEVEL_OFF) bus_rdata = pin_level;
         if (addr_w == FLAG_OFF)  bus_rdata = flags;
      end
   end

   AST_WRITE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr) |-> (bus_rdata == '0)); // R12
endmodule

// File: rtl/pio_bank_sampler.sv
module pio_bank_sampler #(
   parameter int NPINS      = 32,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pad_in,
   input  logic [NPINS-1:0] filt_en,
   output logic [NPINS-1:0] level,
   output logic [NPINS-1:0] chg
);
   logic [NPINS-1:0] sy1;
   logic [NPINS-1:0] sy2;
   logic [NPINS-1:0] sy3;
   logic [NPINS-1:0] lvl_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sy1      <= '0;
         sy2      <= '0;
         sy3      <= '0;
         lvl_prev <= '0;
      end else begin
         sy1      <= pad_in;
         sy2      <= sy1;
         sy3      <= sy2;
         lvl_prev <= level;
      end
   end

   if (HAS_FILTER) begin : g_filter
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         logic held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                held <= 1'b0;
            else if (sy2[i] == sy3[i]) held <= sy2[i];
         end
         assign level[i] = filt_en[i] ? held : sy2[i];

         AST_FILTER_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_en[i] && $past(filt_en[i]) && (level[i] != lvl_prev[i]))
               |-> ($past(sy2[i]) == $past(sy3[i]))); // R9
      end
   end else begin : g_nofilter
      assign level = sy2;
   end

   assign chg = level ^ lvl_prev;
endmodule

// File: rtl/pio_bank_irq.sv
module pio_bank_irq #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] chg,
   input  logic             flag_read,
   input  logic [NPINS-1:0] mask,
   output logic [NPINS-1:0] flags,
   output logic             irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flag_read ? '0 : flags) | chg;
   end

   assign irq = |(flags & mask);

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_read && (chg == '0)) |=> (flags == '0)); // R11
   AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (chg != '0) |=> ((flags & $past(chg)) == $past(chg))); // R11
   AST_FLAGS_STICK: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_read |=> ((flags & $past(flags)) == $past(flags))); // R10
endmodule

// File: rtl/pio_bank_padmux.sv
module pio_bank_padmux #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] gpio_own,
   input  logic [NPINS-1:0] b_pick,
   input  logic [NPINS-1:0] md_en,
   input  logic [NPINS-1:0] gpio_oe,
   input  logic [NPINS-1:0] gpio_val,
   input  logic [NPINS-1:0] a_out,
   input  logic [NPINS-1:0] a_oe,
   input  logic [NPINS-1:0] b_out,
   input  logic [NPINS-1:0] b_oe,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic drv_val;
      logic drv_en;
      assign drv_val = gpio_own[i] ? gpio_val[i] : (b_pick[i] ? b_out[i] : a_out[i]);
      assign drv_en  = gpio_own[i] ? gpio_oe[i]  : (b_pick[i] ? b_oe[i]  : a_oe[i]);
      assign pad_out[i] = ~md_en[i] & drv_val;
      assign pad_oe[i]  = drv_en & ~(md_en[i] & drv_val);

      AST_MD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         md_en[i] |-> !(pad_oe[i] && pad_out[i])); // R6
      AST_GPIO_OFF_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
         (gpio_own[i] && !gpio_oe[i]) |-> !pad_oe[i]); // R5
   end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
   import pio_bank_pkg::*;
#(
   parameter int NPINS      = 32,
   parameter int ADDR_W     = 8,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NPINS-1:0]  bus_wdata,
   output logic [NPINS-1:0]  bus_rdata,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_pu,
   input  logic [NPINS-1:0]  per_a_out,
   input  logic [NPINS-1:0]  per_a_oe,
   output logic [NPINS-1:0]  per_a_in,
   input  logic [NPINS-1:0]  per_b_out,
   input  logic [NPINS-1:0]  per_b_oe,
   output logic [NPINS-1:0]  per_b_in,
   output logic              irq
);
   logic [N_ATTR-1:0][NPINS-1:0] attr_q;
   logic [NPINS-1:0]             level;
   logic [NPINS-1:0]             chg;
   logic [NPINS-1:0]             flags;
   logic                         flag_read;

   pio_bank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pin_level (level),
      .flags     (flags),
      .bus_rdata (bus_rdata),
      .flag_read (flag_read),
      .attr_q    (attr_q)
   );

   pio_bank_sampler #(.NPINS(NPINS), .HAS_FILTER(HAS_FILTER)) u_sampler (
      .clk     (clk),
      .rst_n   (rst_n),
      .pad_in  (pad_in),
      .filt_en (attr_q[AT_FILT]),
      .level   (level),
      .chg     (chg)
   );

   pio_bank_irq #(.NPINS(NPINS)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .chg       (chg),
      .flag_read (flag_read),
      .mask      (attr_q[AT_MASK]),
      .flags     (flags),
      .irq       (irq)
   );

   pio_bank_padmux #(.NPINS(NPINS)) u_padmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .gpio_own (attr_q[AT_PIO]),
      .b_pick   (attr_q[AT_BSEL]),
      .md_en    (attr_q[AT_MD]),
      .gpio_oe  (attr_q[AT_OE]),
      .gpio_val (attr_q[AT_DATA]),
      .a_out    (per_a_out),
      .a_oe     (per_a_oe),
      .b_out    (per_b_out),
      .b_oe     (per_b_oe),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   assign pad_pu   = attr_q[AT_PU];
   assign per_a_in = pad_in;
   assign per_b_in = pad_in;
endmodule

// File: tb/pio_bank_tb_top.sv
module pio_bank_tb_top;
   localparam int NP = 32;
   localparam int NV = 17;

   // {req, write offset, write data, read offset, expected}
   localparam logic [87:0] VEC [NV] = '{
      {8'd4,  8'h30, 32'h000000F0, 8'h38, 32'h000000F0},  // R4 set data
      {8'd4,  8'h34, 32'h00000030, 8'h38, 32'h000000C0},  // R4 clear data
      {8'd5,  8'h10, 32'h000000FF, 8'h18, 32'h000000FF},  // R5 enable out
      {8'd5,  8'h14, 32'h0000000F, 8'h18, 32'h000000F0},  // R5 disable out
      {8'd2,  8'h04, 32'h00000F00, 8'h08, 32'hFFFFF0FF},  // R2 to peripheral
      {8'd2,  8'h00, 32'h00000300, 8'h08, 32'hFFFFF3FF},  // R2 back to GPIO
      {8'd3,  8'h74, 32'h00000C00, 8'h78, 32'h00000C00},  // R3 pick B
      {8'd3,  8'h70, 32'h00000400, 8'h78, 32'h00000800},  // R3 pick A
      {8'd7,  8'h60, 32'hFFFF0000, 8'h68, 32'h0000FFFF},  // R7 pull-up off
      {8'd7,  8'h64, 32'h00010000, 8'h68, 32'h0001FFFF},  // R7 pull-up on
      {8'd6,  8'h50, 32'h00000080, 8'h58, 32'h00000080},  // R6 multi-drive
      {8'd9,  8'h20, 32'h00000005, 8'h28, 32'h00000005},  // R9 filter on
      {8'd9,  8'h24, 32'h00000004, 8'h28, 32'h00000001},  // R9 filter off
      {8'd10, 8'h40, 32'h00000003, 8'h48, 32'h00000003},  // R10 unmask
      {8'd10, 8'h44, 32'h00000002, 8'h48, 32'h00000001},  // R10 mask
      {8'd12, 8'h08, 32'h00000000, 8'h08, 32'hFFFFF3FF},  // R12 status write ignored
      {8'd12, 8'h00, 32'h00000001, 8'h00, 32'h00000000}   // R12 set reg reads 0
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [NP-1:0] bus_wdata = '0;
   logic [NP-1:0] bus_rdata;
   logic [NP-1:0] pad_out, pad_oe, pad_pu, per_a_in, per_b_in;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] per_a_out = '0, per_a_oe = '0, per_b_out = '0, per_b_oe = '0;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pio_bank #(.NPINS(NP), .ADDR_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in), .pad_pu(pad_pu),
      .per_a_out(per_a_out), .per_a_oe(per_a_oe), .per_a_in(per_a_in),
      .per_b_out(per_b_out), .per_b_oe(per_b_oe), .per_b_in(per_b_in),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      @(posedge clk);
      #1 bus_sel = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
      #2;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h08, rv); chk("R1 gpio status", rv, 32'hFFFFFFFF);
      rd(8'h18, rv); chk("R1 oe status", rv, 32'h0);
      rd(8'h48, rv); chk("R1 mask", rv, 32'h0);
      rd(8'h68, rv); chk("R1 pull-up status", rv, 32'hFFFFFFFF);
      rd(8'h4C, rv); chk("R1 flags", rv, 32'h0);
      settle();
      chk("R1 pad_oe", pad_oe, 32'h0);
      chk("R1 pad_pu", pad_pu, 32'hFFFFFFFF);
      chk("R1 irq", {31'b0, irq}, 32'h0);

      // vector table, state accumulates from reset
      for (int v = 0; v < NV; v++) begin
         wr(VEC[v][79:72], VEC[v][71:40]);
         rd(VEC[v][39:32], rv);
         chk($sformatf("R%0d vector %0d", VEC[v][87:80], v), rv, VEC[v][31:0]);
      end
      rd(8'h7C, rv); chk("R12 unused offset", rv, 32'h0);

      // pads: oe 0xF0, data 0xC0, multi-drive on pin 7
      settle();
      chk("R5 pad_oe with md pin high", pad_oe, 32'h00000070);
      chk("R4 pad_out", pad_out, 32'h00000040);
      chk("R7 pad_pu", pad_pu, 32'h0001FFFF);
      wr(8'h34, 32'h00000080);
      settle();
      chk("R6 md pin drives low", pad_oe, 32'h000000F0);
      chk("R6 md pad_out", pad_out, 32'h00000040);

      // peripherals: pin 10 on A, pin 11 on B
      per_a_out = '1; per_a_oe = '1; per_b_out = '0; per_b_oe = '1;
      settle();
      chk("R3 peripheral oe", pad_oe, 32'h00000CF0);
      chk("R3 peripheral out", pad_out, 32'h00000440);

      // R8 pin levels, two-flop latency
      @(negedge clk) pad_in = 32'hA5A50C00;
      rd(8'h3C, rv); chk("R8 level not yet", rv, 32'h0);
      rd(8'h3C, rv); chk("R8 level after two edges", rv, 32'hA5A50C00);
      chk("R8 per_a_in", per_a_in, 32'hA5A50C00);
      chk("R8 per_b_in", per_b_in, 32'hA5A50C00);
      rd(8'h4C, rv); chk("R10 rising flags", rv, 32'hA5A50C00);
      rd(8'h4C, rv); chk("R11 cleared by read", rv, 32'h0);
      @(negedge clk) pad_in = 32'h0;
      repeat (3) @(negedge clk);
      rd(8'h4C, rv); chk("R10 falling flags", rv, 32'hA5A50C00);

      // R10 irq on unmasked pin 1
      wr(8'h40, 32'h00000002);
      @(negedge clk) pad_in = 32'h2;
      repeat (3) @(negedge clk);
      #2 chk("R10 irq high", {31'b0, irq}, 32'h1);
      rd(8'h4C, rv); chk("R10 pin1 flag", rv, 32'h2);
      settle();
      chk("R11 irq low after read", {31'b0, irq}, 32'h0);

      // R9 one-clock pulse on filtered pin 0 and unfiltered pin 2
      @(negedge clk) pad_in = 32'h7;
      @(negedge clk) pad_in = 32'h2;
      repeat (6) @(negedge clk);
      rd(8'h4C, rv); chk("R9 glitch rejected", rv, 32'h4);
      // R9 two-clock pulse accepted on pin 0
      @(negedge clk) pad_in = 32'h3;
      repeat (2) @(negedge clk);
      pad_in = 32'h2;
      repeat (8) @(negedge clk);
      #2 chk("R9 irq from filtered pin", {31'b0, irq}, 32'h1);
      rd(8'h4C, rv); chk("R9 pulse accepted", rv, 32'h1);

      // R11 edge in the cycle of the clearing read
      @(negedge clk) pad_in = 32'hA;
      @(negedge clk);
      rd(8'h4C, rv); chk("R11 read before edge", rv, 32'h0);
      rd(8'h4C, rv); chk("R11 edge kept", rv, 32'h8);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule